// File: doc/BRIEF.md
# Correlating Global-History Branch Predictor

This block predicts the direction of conditional branches. It uses the address of the branch together with the outcomes of the branches that ran just before it. An m-bit global outcome register keeps the most recent resolved directions. That history is placed above the low word-address bits of the branch to index one table of n-bit saturating counters. In effect, each branch address chooses among 2^m separate counters, one for each recent outcome pattern. When m is 0, the block is a plain table of counters indexed by address alone. When m and n are both 1, each address holds two one-bit predictions: one used after a not-taken branch and one used after a taken branch.

A lookup gives the prediction combinationally in the same cycle. It also exposes the history in effect at that moment. The front end keeps that history value with the branch and hands it back when the branch resolves. The update then trains exactly the counter that made the prediction, and the resolved direction is shifted into the history.

Top module: `corr_pred`

## Requirements
- R1: After reset, the history register reads zero and every counter holds 2^(n-1)-1, which predicts not-taken. One taken update of an entry (n=2) makes that entry predict taken.
- R2: The lookup prediction is combinational. It equals the most significant bit of the counter at index {hist_o, lk_addr_i}, with the history in the upper bits; 1 means taken.
- R3: A taken update increments the selected counter and holds it at 2^n-1 when it is already there.
- R4: A not-taken update decrements the selected counter and holds it at 0 when it is already there.
- R5: An update changes only the counter at its own index. Counters at other addresses keep their values, and no counter changes in a cycle without an update.
- R6: An update writes the counter at index {upd_hist_i, upd_addr_i}, using the supplied history and not the current contents of the history register.
- R7: On each update, the history shifts left by one bit, the resolved outcome enters bit 0 (1 = taken), and the oldest bit is dropped.
- R8: The history register keeps its value in every cycle without an update.
- R9: When a lookup and an update select the same entry in one cycle, the lookup returns the value the counter had before the update.
- R10: The same branch address under different history values selects independent counters, so training one history's counter leaves the prediction under another history unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_addr_i | input | ADDR_W | Low word-address bits of the branch being predicted |
| pred_o | output | 1 | Prediction, 1 = taken |
| hist_o | output | max(HIST_W,1) | Global history in effect for the current lookup |
| upd_valid_i | input | 1 | A resolved branch is presented this cycle |
| upd_addr_i | input | ADDR_W | Low word-address bits of the resolved branch |
| upd_hist_i | input | max(HIST_W,1) | History captured at that branch's lookup |
| upd_taken_i | input | 1 | Resolved direction, 1 = taken |

## Verification
The hardest entries to reach are those whose history differs from the value currently in the history register. They can only be observed after the global history has been steered back to that value. The stimulus does this with pairs of sacrificial updates on a scratch address, whose outcome bits spell out the wanted history. Saturation is reached by repeated updates that carry the same supplied history, and it is then read through that steering path. A random phase follows, with a reference model tracking every counter and the history register.

// File: rtl/corr_pred_pkg.sv
package corr_pred_pkg;
  localparam int unsigned MAX_CTR_W = 8;

  // saturating up/down step for a counter of width w (w <= MAX_CTR_W)
  function automatic logic [MAX_CTR_W-1:0] sat_step(
    input logic [MAX_CTR_W-1:0] v,
    input logic                 up,
    input int unsigned          w
  );
    logic [MAX_CTR_W-1:0] top;
    top = (MAX_CTR_W'(1) << w) - MAX_CTR_W'(1);
    if (up) return (v == top) ? v : v + MAX_CTR_W'(1);
    else    return (v == '0)  ? v : v - MAX_CTR_W'(1);
  endfunction
endpackage

// File: rtl/corr_pred_hist.sv
module corr_pred_hist #(
  parameter int HIST_W = 2,
  parameter int HistPw = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [HistPw-1:0] hist_o
);
  if (HIST_W == 0) begin : g_none
    assign hist_o = '0;
  end else if (HIST_W == 1) begin : g_one
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      hist_o <= '0;
      else if (shift_i) hist_o <= bit_i;
    end
  end else begin : g_multi
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      hist_o <= '0;
      else if (shift_i) hist_o <= {hist_o[HIST_W-2:0], bit_i};
    end
  end
endmodule

// File: rtl/corr_pred_idx.sv
module corr_pred_idx #(
  parameter int HIST_W = 2,
  parameter int HistPw = 2,
  parameter int ADDR_W = 4,
  parameter int IDX_W  = 6
) (
  input  logic [HistPw-1:0] hist_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [IDX_W-1:0]  idx_o
);
  if (HIST_W == 0) begin : g_addr_only
    logic unused_hist;
    assign unused_hist = ^hist_i;
    assign idx_o = addr_i;
  end else begin : g_concat
    assign idx_o = {hist_i[HIST_W-1:0], addr_i};
  end
endmodule

// File: rtl/corr_pred_tbl.sv
module corr_pred_tbl
  import corr_pred_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int CTR_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_msb_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_up_i
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam logic [CTR_W-1:0] INIT = CTR_W'((1 << (CTR_W - 1)) - 1);

  logic [CTR_W-1:0] mem [ENTRIES];
  logic [CTR_W-1:0] wr_next;
  logic [MAX_CTR_W-1:0] step_full;

  assign step_full = sat_step(MAX_CTR_W'(mem[wr_idx_i]), wr_up_i, CTR_W);
  assign wr_next   = step_full[CTR_W-1:0];
  assign rd_msb_o  = mem[rd_idx_i][CTR_W-1]; // old value on same-cycle hit

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) mem[i] <= INIT;
    end else if (wr_en_i) begin
      mem[wr_idx_i] <= wr_next;
    end
  end

  logic unused_step;
  assign unused_step = ^step_full;
endmodule

// File: rtl/corr_pred.sv
module corr_pred #(
  parameter int HIST_W = 2,
  parameter int CTR_W  = 2,
  parameter int ADDR_W = 4,
  localparam int HistPw = (HIST_W > 0) ? HIST_W : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] lk_addr_i,
  output logic              pred_o,
  output logic [HistPw-1:0] hist_o,
  input  logic              upd_valid_i,
  input  logic [ADDR_W-1:0] upd_addr_i,
  input  logic [HistPw-1:0] upd_hist_i,
  input  logic              upd_taken_i
);
  localparam int IDX_W = HIST_W + ADDR_W;

  logic [IDX_W-1:0] lk_idx, upd_idx;

  corr_pred_hist #(.HIST_W(HIST_W), .HistPw(HistPw)) u_hist (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .shift_i(upd_valid_i), .bit_i(upd_taken_i), .hist_o(hist_o)
  );

  corr_pred_idx #(.HIST_W(HIST_W), .HistPw(HistPw), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_lk_idx (
    .hist_i(hist_o), .addr_i(lk_addr_i), .idx_o(lk_idx)
  );

  corr_pred_idx #(.HIST_W(HIST_W), .HistPw(HistPw), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_upd_idx (
    .hist_i(upd_hist_i), .addr_i(upd_addr_i), .idx_o(upd_idx)
  );

  corr_pred_tbl #(.IDX_W(IDX_W), .CTR_W(CTR_W)) u_tbl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .rd_idx_i(lk_idx), .rd_msb_o(pred_o),
    .wr_en_i(upd_valid_i), .wr_idx_i(upd_idx), .wr_up_i(upd_taken_i)
  );
endmodule

// File: rtl/corr_pred_chk.sv
module corr_pred_chk #(
  parameter int HIST_W = 2,
  parameter int ADDR_W = 4,
  parameter int HistPw = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] lk_addr_i,
  input logic              pred_o,
  input logic [HistPw-1:0] hist_o,
  input logic              upd_valid_i,
  input logic              upd_taken_i
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) p_rst_hist_r1: assert (hist_o == '0);
  end

  p_hist_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !upd_valid_i) |=> $stable(hist_o));

  p_pred_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !upd_valid_i) |=>
      (!($stable(lk_addr_i) && $stable(hist_o)) || $stable(pred_o)));

  if (HIST_W >= 1) begin : g_lsb
    p_hist_lsb_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (past_ok && upd_valid_i) |=> (hist_o[0] == $past(upd_taken_i)));
  end

  if (HIST_W >= 2) begin : g_shift
    p_hist_shift_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (past_ok && upd_valid_i) |=> (hist_o[HIST_W-1:1] == $past(hist_o[HIST_W-2:0])));
  end
endmodule

bind corr_pred corr_pred_chk #(.HIST_W(HIST_W), .ADDR_W(ADDR_W), .HistPw(HistPw)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .lk_addr_i(lk_addr_i), .pred_o(pred_o),
  .hist_o(hist_o), .upd_valid_i(upd_valid_i), .upd_taken_i(upd_taken_i)
);

// File: tb/tb_corr_pred.sv
`timescale 1ns/1ps
module tb_corr_pred;
  localparam int HW  = 2;
  localparam int CW  = 2;
  localparam int AW  = 4;
  localparam int ENT = 1 << (HW + AW);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_ni;
  logic [AW-1:0] lk_addr_i, upd_addr_i;
  logic          pred_o, upd_valid_i, upd_taken_i;
  logic [HW-1:0] hist_o, upd_hist_i;

  corr_pred #(.HIST_W(HW), .CTR_W(CW), .ADDR_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .lk_addr_i(lk_addr_i), .pred_o(pred_o),
    .hist_o(hist_o), .upd_valid_i(upd_valid_i), .upd_addr_i(upd_addr_i),
    .upd_hist_i(upd_hist_i), .upd_taken_i(upd_taken_i)
  );

  int    model [ENT];
  int    hist_m;
  bit    q_pred [$];
  int    q_hist [$];
  string q_tag  [$];
  int    checks = 0;
  int    errors = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // driver: drive one cycle, push expectation, advance the model
  task automatic step(input int la, input bit uv, input int ua, input int uh,
                      input bit tk, input string tag);
    int k;
    @(negedge clk);
    lk_addr_i   = AW'(la);
    upd_valid_i = uv;
    upd_addr_i  = AW'(ua);
    upd_hist_i  = HW'(uh);
    upd_taken_i = tk;
    q_pred.push_back(model[(hist_m << AW) | la] >= (1 << (CW - 1)));
    q_hist.push_back(hist_m);
    q_tag.push_back(tag);
    if (uv) begin
      k = (uh << AW) | ua;
      if (tk && model[k] < (1 << CW) - 1) model[k]++;
      else if (!tk && model[k] > 0)        model[k]--;
      hist_m = ((hist_m << 1) | int'(tk)) & ((1 << HW) - 1);
    end
  endtask

  task automatic look(input int la, input string tag);
    step(la, 1'b0, 0, 0, 1'b0, tag);
  endtask

  // steer history to h using scratch address 15
  task automatic set_hist(input int h);
    step(15, 1'b1, 15, 3, h[1], "R7 steer");
    step(15, 1'b1, 15, 3, h[0], "R7 steer");
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (q_pred.size() > 0) begin
        bit    ep;
        int    eh;
        string t;
        ep = q_pred.pop_front();
        eh = q_hist.pop_front();
        t  = q_tag.pop_front();
        chk(pred_o == ep, {t, " (R2 pred)"}, int'(pred_o), int'(ep));
        chk(int'(hist_o) == eh, {t, " (R7/R8 hist)"}, int'(hist_o), eh);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < ENT; i++) model[i] = (1 << (CW - 1)) - 1;
    hist_m = 0;
    rst_ni = 1'b0;
    lk_addr_i = '0; upd_valid_i = 1'b0; upd_addr_i = '0; upd_hist_i = '0; upd_taken_i = 1'b0;
    repeat (2) @(negedge clk);
    lk_addr_i = 4'd5;
    #1;
    chk(hist_o == '0, "R1 hist in reset", int'(hist_o), 0);
    chk(pred_o == 1'b0, "R1 pred in reset", int'(pred_o), 0);
    @(negedge clk);
    rst_ni = 1'b1;

    for (int a = 0; a < 16; a++) look(a, "R1 weak not-taken after reset");

    step(3, 1'b1, 3, 0, 1'b1, "R1 first taken update");
    look(3, "R10 other history table untouched");
    set_hist(0);
    look(3, "R1 one taken flips prediction");

    step(3, 1'b1, 3, 0, 1'b0, "R9 same-cycle pre-update value");
    set_hist(0);
    look(3, "R9 write landed after cycle");

    step(5, 1'b1, 5, 2, 1'b1, "R6 update with supplied history");
    set_hist(2);
    look(5, "R6 supplied-history entry trained");
    set_hist(0);
    look(5, "R6 current-history entry untouched");
    look(4, "R5 neighbour address untouched");
    look(6, "R5 neighbour address untouched");

    for (int i = 0; i < 5; i++) step(0, 1'b1, 7, 1, 1'b1, "R3 drive to top");
    step(0, 1'b1, 7, 1, 1'b0, "R3 one step down");
    set_hist(1);
    look(7, "R3 saturated high then decremented");

    for (int i = 0; i < 3; i++) step(0, 1'b1, 8, 3, 1'b0, "R4 drive to bottom");
    step(0, 1'b1, 8, 3, 1'b1, "R4 one step up");
    set_hist(3);
    look(8, "R4 saturated low then incremented");
    step(0, 1'b1, 8, 3, 1'b1, "R4 second step up");
    set_hist(3);
    look(8, "R4 reaches taken");

    for (int i = 0; i < 4; i++) look(i, "R8 hold without update");

    for (int i = 0; i < 400; i++)
      step(int'($urandom_range(15)), 1'($urandom_range(1)), int'($urandom_range(15)),
           int'($urandom_range(3)), 1'($urandom_range(1)), "R2 random");

    look(0, "R8 idle");
    look(1, "R8 idle");
    wait (q_pred.size() == 0);
    @(negedge clk);
    #2;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule